// File: doc/BRIEF.md
# Synchronous SRAM Core with Selectable Read Latency

This block is a single-port synchronous SRAM with a registered command stage, a byte-lane storage array and an output stage. Address, chip select, write controls and write data are captured on the rising clock edge. A captured write updates the array on the following edge. A captured read returns data either in the cycle right after capture (flow-through) or one cycle later through an output register (pipeline). A static strap input picks between the two.

Writes come in two kinds. A byte write is enabled by a byte-write enable together with active-low per-lane strobes. A global write stores every lane and overrides all byte controls. An asynchronous output enable and an asynchronous sleep input gate the output-valid flag directly. Sleep also turns every captured command into an idle cycle, so the stored contents are kept. The read data bus is zero whenever it is not flagged valid.

Top module: `ssram_core`

## Requirements
- R1: With `pipe_mode` low, a read captured at clock edge k shows the addressed word on `dout` with `dout_en` high from edge k until edge k+1.
- R2: With `pipe_mode` high, a read captured at edge k shows its word from edge k+1 until edge k+2, and `dout_en` stays low between edge k and edge k+1 unless an earlier read was captured at edge k-1.
- R3: A deselect (`cs` low) or a write captured at edge k turns `dout_en` off. In flow-through mode it goes off right after edge k. In pipeline mode it goes off after edge k+1, with no extra hold cycle after the last read word.
- R4: With `gw_n` high and `bwe_n` low, lane i (`din[8i+7:8i]`) is written only where `byte_we_n[i]` is 0. The other lanes keep their old bytes.
- R5: With `gw_n` low and `cs` high, all lanes are written, whatever `bwe_n` and `byte_we_n` are.
- R6: With `cs` high, `gw_n` high, and either `bwe_n` high or all `byte_we_n` bits high, the cycle is a read and the array is unchanged.
- R7: `oe_n` high forces `dout_en` low without waiting for a clock edge. Returning it low restores the pending output.
- R8: While `sleep` is high, `dout_en` is low at once and captured commands are ignored. The array keeps its contents through sleep.
- R9: A read captured on the edge right after a write to the same address returns the newly written word, in both modes.
- R10: While `rst` is high, the command stage is idle, the output register is cleared and `dout_en` is low.
- R11: `dout` is all zeros whenever `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | $clog2(DEPTH) | Word address |
| cs | input | 1 | Chip select, high to start a read or write |
| byte_we_n | input | NB | Per-lane write strobes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| pipe_mode | input | 1 | Static strap: 1 = pipeline, 0 = flow-through |
| din | input | NB*8 | Write data |
| dout | output | NB*8 | Read data, zero when not valid |
| dout_en | output | 1 | Read data valid / output drive indication |

## Verification
The bench builds the core with DEPTH=16 and NB=4. The lowest and highest addresses (0 and 15) are reached directly, and a four-lane word allows mixed strobe patterns such as alternate lanes or a single top lane. It walks a vector table in flow-through mode, then switches the strap to pipeline mode to test latency, turn-off timing and write-then-read. It finishes with the asynchronous output enable, sleep with a pending write, and reset in the middle of a read.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Classify one sampled cycle. Sleep or an unselected chip gives an idle cycle.
    function automatic op_e decode_op(
        input logic sel,
        input logic nap,
        input logic glob_n,
        input logic bytes_n,
        input logic any_lane
    );
        if (nap || !sel)
            return OP_IDLE;
        if (!glob_n)
            return OP_WRITE;
        if (!bytes_n && any_lane)
            return OP_WRITE;
        return OP_READ;
    endfunction

endpackage

// File: rtl/ssram_cmd_reg.sv
module ssram_cmd_reg
    import ssram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    localparam int DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          cs,
    input  logic [NB-1:0] byte_we_n,
    input  logic          bwe_n,
    input  logic          gw_n,
    input  logic          sleep,
    input  logic [DW-1:0] din,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [NB-1:0] lanes_q
);

    op_e           op_d;
    logic [NB-1:0] lanes_d;
    logic          any_lane;

    always_comb begin
        any_lane = |(~byte_we_n);
        op_d     = decode_op(cs, sleep, gw_n, bwe_n, any_lane);
        lanes_d  = (!gw_n) ? {NB{1'b1}} : ~byte_we_n;
    end

    always_ff @(posedge clk) begin
        if (rst)
            op_q <= OP_IDLE;
        else
            op_q <= op_d;
        addr_q  <= addr;
        data_q  <= din;
        lanes_q <= lanes_d;
    end

    // R8: a command sampled during sleep must not reach the array or output stage
    a_r8_sleep_ignored: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (op_q == OP_IDLE));

    // R6: a registered write always carries at least one lane
    a_r6_write_has_lane: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_WRITE) |-> (lanes_q != '0));

    // R5: a global write sampled while selected and awake reaches every lane
    a_r5_global_all: assert property (@(posedge clk) disable iff (rst)
        (cs && !sleep && !gw_n) |=> (op_q == OP_WRITE && lanes_q == {NB{1'b1}}));

endmodule

// File: rtl/ssram_array.sv
module ssram_array
    import ssram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LANE_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [NB-1:0] lanes,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lanes[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];

        // R4: an enabled lane holds the written byte after the edge
        a_r4_lane_write: assert property (@(posedge clk)
            (we && lanes[g]) |=> (mem[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/ssram_outstage.sv
module ssram_outstage
    import ssram_pkg::*;
#(
    parameter int NB = 4,
    localparam int DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          sleep,
    input  op_e           op_q,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    logic          pvalid;
    logic [DW-1:0] pdata;
    logic          src_valid;
    logic [DW-1:0] src_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pvalid <= 1'b0;
            pdata  <= '0;
        end else begin
            pvalid <= (op_q == OP_READ);
            if (op_q == OP_READ)
                pdata <= rdata;
        end
    end

    always_comb begin
        src_valid = pipe_mode ? pvalid : (op_q == OP_READ);
        src_data  = pipe_mode ? pdata  : rdata;
        dout_en   = src_valid && !oe_n && !sleep;
        dout      = dout_en ? src_data : '0;
    end

    // R3: in flow-through mode a non-read stage leaves the outputs dark
    a_r3_flow_off: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && op_q != OP_READ) |-> !dout_en);

    // R3: in pipeline mode a non-read stage darkens the outputs one edge later
    a_r3_pipe_off: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && op_q != OP_READ) |=> (!pipe_mode || !dout_en));

    // R2: pipeline output carries the word the array gave one cycle earlier
    a_r2_pipe_data: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && op_q == OP_READ) |=>
            (!pipe_mode || oe_n || sleep || (dout_en && dout == $past(rdata))));

endmodule

// File: rtl/ssram_core.sv
module ssram_core
    import ssram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          cs,
    input  logic [NB-1:0] byte_we_n,
    input  logic          bwe_n,
    input  logic          gw_n,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic          pipe_mode,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [NB-1:0] lanes_q;
    logic [DW-1:0] rdata;

    ssram_cmd_reg #(.AW(AW), .NB(NB)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .cs        (cs),
        .byte_we_n (byte_we_n),
        .bwe_n     (bwe_n),
        .gw_n      (gw_n),
        .sleep     (sleep),
        .din       (din),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .lanes_q   (lanes_q)
    );

    ssram_array #(.DEPTH(DEPTH), .NB(NB)) u_array (
        .clk   (clk),
        .we    (op_q == OP_WRITE),
        .lanes (lanes_q),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (rdata)
    );

    ssram_outstage #(.NB(NB)) u_out (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .op_q      (op_q),
        .rdata     (rdata),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    // R8: sleep keeps the data outputs dark
    a_r8_sleep_dark: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_en);

    // R10: the edge after a reset cycle sees no valid output
    a_r10_reset_dark: assert property (@(posedge clk)
        rst |=> !dout_en);

endmodule

// File: tb/sim_ssram_core.sv
module sim_ssram_core;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int NB     = 4;
    localparam int AW     = $clog2(DEPTH);
    localparam int DW     = NB * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          cs;
    logic [NB-1:0] byte_we_n;
    logic          bwe_n;
    logic          gw_n;
    logic          oe_n;
    logic          sleep;
    logic          pipe_mode;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ssram_core #(.DEPTH(DEPTH), .NB(NB)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .cs(cs), .byte_we_n(byte_we_n),
        .bwe_n(bwe_n), .gw_n(gw_n), .oe_n(oe_n), .sleep(sleep),
        .pipe_mode(pipe_mode), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic          cs;
        logic          gw_n;
        logic          bwe_n;
        logic [3:0]    bw_n;
        logic [3:0]    adr;
        logic [31:0]   dat;
        logic          exp_en;
        logic [31:0]   exp_dat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b1, 4'b1111, 4'd3,  32'h11223344, 1'b0, 32'h0},          // R5 full write
        '{1'b1, 1'b0, 1'b1, 4'b1111, 4'd15, 32'hAABBCCDD, 1'b0, 32'h0},          // R5 top address
        '{1'b1, 1'b0, 1'b1, 4'b1111, 4'd0,  32'h0F0F0F0F, 1'b0, 32'h0},          // R5 bottom address
        '{1'b1, 1'b1, 1'b0, 4'b1010, 4'd3,  32'h55667788, 1'b0, 32'h0},          // R4 lanes 0 and 2
        '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd3,  32'h0,        1'b1, 32'h11663388},   // R4 R1 merged word
        '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd15, 32'h0,        1'b1, 32'hAABBCCDD},   // R1
        '{1'b1, 1'b1, 1'b1, 4'b0000, 4'd15, 32'hFFFFFFFF, 1'b1, 32'hAABBCCDD},   // R6 strobes without enable
        '{1'b1, 1'b1, 1'b0, 4'b1111, 4'd0,  32'hFFFFFFFF, 1'b1, 32'h0F0F0F0F},   // R6 enable without strobes
        '{1'b1, 1'b0, 1'b0, 4'b1110, 4'd0,  32'h12345678, 1'b0, 32'h0},          // R5 overrides byte controls
        '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd0,  32'h0,        1'b1, 32'h12345678},   // R5 R9
        '{1'b0, 1'b1, 1'b1, 4'b1111, 4'd3,  32'h0,        1'b0, 32'h0},          // R3 R11 deselect
        '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd3,  32'h0,        1'b1, 32'h11663388},   // R1
        '{1'b1, 1'b1, 1'b0, 4'b0111, 4'd15, 32'h99FFFFFF, 1'b0, 32'h0},          // R4 top lane only
        '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd15, 32'h0,        1'b1, 32'h99BBCCDD}    // R4 R9
    };

    task automatic check(input string req, input logic en_exp, input logic [31:0] d_exp);
        checks++;
        if (dout_en !== en_exp || dout !== d_exp) begin
            errors++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     req, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic put(input logic c, input logic g, input logic b, input logic [3:0] s,
                       input logic [3:0] a, input logic [31:0] d);
        cs = c; gw_n = g; bwe_n = b; byte_we_n = s; addr = a; din = d;
    endtask

    task automatic rd(input logic [3:0] a);
        put(1'b1, 1'b1, 1'b1, 4'b1111, a, 32'h0);
    endtask

    task automatic idle();
        put(1'b0, 1'b1, 1'b1, 4'b1111, 4'd0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; oe_n = 1'b0; sleep = 1'b0; pipe_mode = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        check("R10 reset state", 1'b0, 32'h0);
        rst = 1'b0;

        // Table walk in flow-through mode: each result sampled one edge after capture
        for (int i = 0; i < NV; i++) begin
            put(VEC[i].cs, VEC[i].gw_n, VEC[i].bwe_n, VEC[i].bw_n, VEC[i].adr, VEC[i].dat);
            @(negedge clk);
            check($sformatf("R1/R3-R6/R9 vector %0d", i), VEC[i].exp_en, VEC[i].exp_dat);
        end

        // Flow-through: read then deselect darkens after the deselect edge
        rd(4'd15); @(negedge clk);
        check("R1 flow read", 1'b1, 32'h99BBCCDD);
        idle(); @(negedge clk);
        check("R3 flow deselect", 1'b0, 32'h0);

        // Pipeline mode
        @(negedge clk);
        pipe_mode = 1'b1;
        rd(4'd3); @(negedge clk);
        check("R2 pipeline first edge", 1'b0, 32'h0);
        rd(4'd15); @(negedge clk);
        check("R2 pipeline data", 1'b1, 32'h11663388);
        idle(); @(negedge clk);
        check("R2 pipeline back-to-back", 1'b1, 32'h99BBCCDD);
        @(negedge clk);
        check("R3 pipeline deselect off", 1'b0, 32'h0);

        put(1'b1, 1'b0, 1'b1, 4'b1111, 4'd5, 32'hDEADBEEF); @(negedge clk);
        check("R3 pipeline write dark", 1'b0, 32'h0);
        rd(4'd5); @(negedge clk);
        check("R9 pipeline read latency", 1'b0, 32'h0);
        idle(); @(negedge clk);
        check("R9 pipeline write-then-read", 1'b1, 32'hDEADBEEF);
        @(negedge clk);
        pipe_mode = 1'b0;

        // Asynchronous output enable
        rd(4'd3); @(negedge clk);
        check("R7 before oe", 1'b1, 32'h11663388);
        oe_n = 1'b1; #1;
        check("R7 R11 oe high", 1'b0, 32'h0);
        oe_n = 1'b0; #1;
        check("R7 oe restored", 1'b1, 32'h11663388);

        // Sleep: outputs dark at once, pending write ignored, data kept
        sleep = 1'b1; #1;
        check("R8 sleep dark", 1'b0, 32'h0);
        put(1'b1, 1'b0, 1'b1, 4'b1111, 4'd3, 32'h00000000);
        @(negedge clk);
        check("R8 sleep write ignored", 1'b0, 32'h0);
        @(negedge clk);
        sleep = 1'b0;
        rd(4'd3); @(negedge clk);
        check("R8 data retained", 1'b1, 32'h11663388);

        // Reset during a read
        rst = 1'b1; @(negedge clk);
        check("R10 reset mid-read", 1'b0, 32'h0);
        rst = 1'b0; idle(); @(negedge clk);
        check("R10 idle after reset", 1'b0, 32'h0);

        finish_run();
    end

endmodule